// File: doc/BRIEF.md
# Burst-Mode Dual-Address DMA Transfer Sequencer

This block is the control engine of one DMA channel that moves data in dual-address fashion: every transfer unit reads one byte or one word from a source address and then writes it to a destination address. In burst mode the units follow one another without a gap and without giving up the bus, until the remaining-unit counter reaches zero. After the final write, one idle dead state is inserted, and then the bus is handed back with a release indication and a completion pulse.

Software-side logic loads the unit count, the source and destination addresses, the unit size, the two address-increment enables and the transfer-end enable with a start pulse. The start pulse also enables the channel. A non-maskable abort input clears the channel enable at any time. If a non-final unit is in flight, that unit finishes and the channel then stops at the unit boundary, keeping its remaining count and its current addresses. An enable-set pulse lets the channel resume from that point. If the final unit has already begun when the abort arrives, the burst still finishes normally. A higher-priority requester is granted only while this channel is idle, so it cannot break into a burst.

The sequencer has seven states. IDLE goes to RD1 when the channel is enabled, the count is non-zero, no abort or start is present and no higher-priority request is pending. RD1 goes to RD2, which captures the read data. RD2 goes to WR1, and WR1 goes to WR2. WR2 ends a unit and goes to one of three states: DEAD when that unit was the last one, REL when the enable is off (suspend), or RD1 otherwise (burst continues). DEAD goes to REL. REL goes to IDLE.

Top module: `dma_burst_seq`

## Requirements
- R1: After reset the channel is disabled, idle, and the count and both addresses are zero. A start pulse in IDLE loads the count, the addresses and the mode, and sets the enable. When the loaded count is zero, no bus cycle runs and `done_o` stays low.
- R2: Each unit is two states with `bus_rd_o`=1 and `bus_addr_o` equal to the source address, then two states with `bus_wr_o`=1 and `bus_addr_o` equal to the destination address. During both write states `bus_wdata_o` equals the `bus_rdata_i` sampled in the second read state. `bus_word_o`=1 marks word units. When neither strobe is high, `bus_addr_o` and `bus_wdata_o` are zero.
- R3: Units run back to back with `busy_o` held high. The count drops by exactly one at the end of each unit. Each address whose increment enable is set advances by 2 for word units (`cfg_word_i`=1) or by 1 for byte units. An address whose increment enable is clear stays unchanged.
- R4: After the write of the unit that brings the count to zero, there is exactly one state with no strobe and `busy_o`=1. The next state has `bus_rel_o`=1 and `done_o`=1. The state after that is idle.
- R5: `tend_o` is high during all four bus states of the final unit when the transfer-end enable was loaded as 1, and low at all other times.
- R6: `hp_grant_o` equals `hp_req_i` while the channel is idle and is 0 while `busy_o`=1. A pending `hp_req_i` keeps an idle channel from starting.
- R7: `abort_i` clears `chan_en_o` at the next edge in every state. It takes priority over `start_i` and `en_set_i` in the same cycle.
- R8: An abort during a non-final unit lets that unit finish. The unit's read and write complete, the count decrements and the addresses advance. Then comes one release state (`bus_rel_o`=1, `done_o`=0) with no dead state, and the count and addresses are kept.
- R9: An abort that arrives once the final unit has started does not shorten the burst. The unit completes, `tend_o` stays high, and the dead state and `done_o` follow.
- R10: An `en_set_i` pulse on an idle channel with a non-zero count resumes the burst from the kept count and addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load configuration and enable (acted on in IDLE only) |
| cfg_count_i | input | CNT_W | Number of units to transfer |
| cfg_src_i | input | ADDR_W | Initial source address |
| cfg_dst_i | input | ADDR_W | Initial destination address |
| cfg_word_i | input | 1 | 1 = word units, 0 = byte units |
| cfg_src_inc_i | input | 1 | Advance the source address after each unit |
| cfg_dst_inc_i | input | 1 | Advance the destination address after each unit |
| cfg_tend_en_i | input | 1 | Enable the transfer-end output |
| en_set_i | input | 1 | Set the channel enable (resume) |
| abort_i | input | 1 | Non-maskable abort; clears the enable |
| hp_req_i | input | 1 | Request from a higher-priority channel |
| hp_grant_o | output | 1 | Grant to the higher-priority channel |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_word_o | output | 1 | Unit size of the current access |
| bus_wdata_o | output | DATA_W | Write data |
| bus_rdata_i | input | DATA_W | Read data |
| tend_o | output | 1 | Transfer-end indication during the final unit |
| bus_rel_o | output | 1 | Bus handed back this cycle |
| done_o | output | 1 | Normal completion pulse |
| busy_o | output | 1 | Sequencer holds the bus |
| chan_en_o | output | 1 | Channel enable |
| rem_count_o | output | CNT_W | Remaining units |
| cur_src_o | output | ADDR_W | Current source address |
| cur_dst_o | output | ADDR_W | Current destination address |

## Verification
Bursts are run with word units and both addresses incrementing, and with byte units and a fixed destination. These runs separate the step size from the increment enables and confirm the dead state and the release timing. Starting with a zero count, and starting while a higher-priority request is held, show that nothing begins that should not. A request raised mid-burst shows that preemption is held off. An abort is placed inside a non-final unit, inside the final unit, and in the same cycle as a start. These three cases separate suspension at a unit boundary from forced completion and from enable priority. Resuming with the enable-set pulse confirms that the kept count and addresses are used.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD1  = 3'd1,
        ST_RD2  = 3'd2,
        ST_WR1  = 3'd3,
        ST_WR2  = 3'd4,
        ST_DEAD = 3'd5,
        ST_REL  = 3'd6
    } seq_state_t;

    localparam int NUM_PTRS = 2;
    localparam int PTR_SRC  = 0;
    localparam int PTR_DST  = 1;
endpackage

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);
    assign last_o = (cnt_q == ONE);

    // R3: a unit never ends with nothing left to transfer
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> cnt_q != '0);
endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              step_i,
    input  logic              inc_en_i,
    input  logic              word_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] stride;

    assign stride = {{(ADDR_W-2){1'b0}}, word_i, ~word_i};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_i) begin
            addr_q <= load_val_i;
        end else if (step_i && inc_en_i) begin
            addr_q <= addr_q + stride;
        end
    end

    assign addr_o = addr_q;

    // R3: a fixed pointer does not move
    assert_fixed_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !inc_en_i) |=> $stable(addr_q));
endmodule

// File: rtl/dma_burst_fsm.sv
module dma_burst_fsm
    import dma_burst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_en_i,
    input  logic       en_set_i,
    input  logic       abort_i,
    input  logic       start_i,
    input  logic       cnt_zero_i,
    input  logic       cnt_last_i,
    input  logic       hp_req_i,
    output seq_state_t state_o,
    output logic       rd_o,
    output logic       wr_o,
    output logic       capture_o,
    output logic       unit_end_o,
    output logic       in_unit_o,
    output logic       idle_o,
    output logic       rel_o,
    output logic       fin_o
);
    seq_state_t state_q, state_d;
    logic       fin_q, fin_d;
    logic       en_after;

    assign en_after = (chan_en_i || en_set_i) && !abort_i;

    always_comb begin
        state_d = state_q;
        fin_d   = fin_q;
        unique case (state_q)
            ST_IDLE: begin
                if (chan_en_i && !abort_i && !start_i && !cnt_zero_i && !hp_req_i) begin
                    state_d = ST_RD1;
                end
            end
            ST_RD1:  state_d = ST_RD2;
            ST_RD2:  state_d = ST_WR1;
            ST_WR1:  state_d = ST_WR2;
            ST_WR2: begin
                if (cnt_last_i) begin
                    state_d = ST_DEAD;
                    fin_d   = 1'b1;
                end else if (!en_after) begin
                    state_d = ST_REL;
                    fin_d   = 1'b0;
                end else begin
                    state_d = ST_RD1;
                end
            end
            ST_DEAD: state_d = ST_REL;
            ST_REL:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fin_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            fin_q   <= fin_d;
        end
    end

    always_comb begin
        rd_o       = 1'b0;
        wr_o       = 1'b0;
        capture_o  = 1'b0;
        unit_end_o = 1'b0;
        idle_o     = 1'b0;
        rel_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: idle_o = 1'b1;
            ST_RD1:  rd_o   = 1'b1;
            ST_RD2: begin
                rd_o      = 1'b1;
                capture_o = 1'b1;
            end
            ST_WR1:  wr_o   = 1'b1;
            ST_WR2: begin
                wr_o       = 1'b1;
                unit_end_o = 1'b1;
            end
            ST_DEAD: ;
            ST_REL:  rel_o  = 1'b1;
            default: idle_o = 1'b1;
        endcase
    end

    assign in_unit_o = rd_o || wr_o;
    assign fin_o     = fin_q;
    assign state_o   = state_q;

    // R2: every read strobe is followed by a write strobe two states later
    assert_read_then_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD2) |=> (state_q == ST_WR1));
endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
    import dma_burst_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  cfg_count_i,
    input  logic [ADDR_W-1:0] cfg_src_i,
    input  logic [ADDR_W-1:0] cfg_dst_i,
    input  logic              cfg_word_i,
    input  logic              cfg_src_inc_i,
    input  logic              cfg_dst_inc_i,
    input  logic              cfg_tend_en_i,
    input  logic              en_set_i,
    input  logic              abort_i,
    input  logic              hp_req_i,
    output logic              hp_grant_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_rd_o,
    output logic              bus_wr_o,
    output logic              bus_word_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic              tend_o,
    output logic              bus_rel_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              chan_en_o,
    output logic [CNT_W-1:0]  rem_count_o,
    output logic [ADDR_W-1:0] cur_src_o,
    output logic [ADDR_W-1:0] cur_dst_o
);
    seq_state_t        state;
    logic              rd, wr, capture, unit_end, in_unit, idle, rel, fin;
    logic              en_q, load;
    logic              word_q, src_inc_q, dst_inc_q, tend_en_q;
    logic [DATA_W-1:0] data_q;
    logic              cnt_zero, cnt_last;
    logic [CNT_W-1:0]  cnt;

    logic [NUM_PTRS-1:0][ADDR_W-1:0] ptr_load, ptr_val;
    logic [NUM_PTRS-1:0]             ptr_inc;

    assign load = start_i && idle;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (abort_i) begin
            en_q <= 1'b0;
        end else if (en_set_i || load) begin
            en_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q    <= 1'b0;
            src_inc_q <= 1'b0;
            dst_inc_q <= 1'b0;
            tend_en_q <= 1'b0;
        end else if (load) begin
            word_q    <= cfg_word_i;
            src_inc_q <= cfg_src_inc_i;
            dst_inc_q <= cfg_dst_inc_i;
            tend_en_q <= cfg_tend_en_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (capture) begin
            data_q <= bus_rdata_i;
        end
    end

    dma_burst_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en_i  (en_q),
        .en_set_i   (en_set_i),
        .abort_i    (abort_i),
        .start_i    (start_i),
        .cnt_zero_i (cnt_zero),
        .cnt_last_i (cnt_last),
        .hp_req_i   (hp_req_i),
        .state_o    (state),
        .rd_o       (rd),
        .wr_o       (wr),
        .capture_o  (capture),
        .unit_end_o (unit_end),
        .in_unit_o  (in_unit),
        .idle_o     (idle),
        .rel_o      (rel),
        .fin_o      (fin)
    );

    dma_xfer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (cfg_count_i),
        .dec_i      (unit_end),
        .cnt_o      (cnt),
        .zero_o     (cnt_zero),
        .last_o     (cnt_last)
    );

    assign ptr_load[PTR_SRC] = cfg_src_i;
    assign ptr_load[PTR_DST] = cfg_dst_i;
    assign ptr_inc[PTR_SRC]  = src_inc_q;
    assign ptr_inc[PTR_DST]  = dst_inc_q;

    for (genvar g = 0; g < NUM_PTRS; g++) begin : g_ptr
        dma_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (load),
            .load_val_i (ptr_load[g]),
            .step_i     (unit_end),
            .inc_en_i   (ptr_inc[g]),
            .word_i     (word_q),
            .addr_o     (ptr_val[g])
        );
    end

    assign bus_rd_o    = rd;
    assign bus_wr_o    = wr;
    assign bus_word_o  = word_q;
    assign bus_addr_o  = rd ? ptr_val[PTR_SRC] : (wr ? ptr_val[PTR_DST] : '0);
    assign bus_wdata_o = wr ? data_q : '0;
    assign tend_o      = in_unit && cnt_last && tend_en_q;
    assign bus_rel_o   = rel;
    assign done_o      = rel && fin;
    assign busy_o      = !idle;
    assign hp_grant_o  = hp_req_i && idle;
    assign chan_en_o   = en_q;
    assign rem_count_o = cnt;
    assign cur_src_o   = ptr_val[PTR_SRC];
    assign cur_dst_o   = ptr_val[PTR_DST];

    // R2: strobes are exclusive and each access lasts two states at a steady address
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd_o && bus_wr_o));
    assert_rd_two_states_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rd_o) |=> bus_rd_o && $stable(bus_addr_o));
    // R4: completion is preceded by a dead state
    assert_dead_before_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy_o && !bus_rd_o && !bus_wr_o) && rem_count_o == '0);
    // R5: transfer-end only while one unit remains
    assert_tend_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tend_o |-> rem_count_o == {{(CNT_W-1){1'b0}}, 1'b1});
    // R6: no grant while the burst holds the bus
    assert_no_grant_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !hp_grant_o);
    // R7: abort always clears the enable
    assert_abort_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !chan_en_o);
    // R8: a suspension release happens with the channel disabled
    assert_suspend_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rel_o && !done_o) |-> !chan_en_o);
endmodule

// File: tb/dma_burst_seq_tb_top.sv
module dma_burst_seq_tb_top;
    localparam int AW = 24;
    localparam int CW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, cfg_word = 1'b0, src_inc = 1'b0, dst_inc = 1'b0, tend_en = 1'b0;
    logic [CW-1:0] cfg_count = '0;
    logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
    logic          en_set = 1'b0, abort = 1'b0, hp_req = 1'b0;
    logic          hp_grant, bus_rd, bus_wr, bus_word, tend, bus_rel, done, busy, chan_en;
    logic [AW-1:0] bus_addr, cur_src, cur_dst;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic [CW-1:0] rem_count;

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] mem_of(logic [AW-1:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    assign bus_rdata = mem_of(bus_addr);

    dma_burst_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_count_i(cfg_count),
        .cfg_src_i(cfg_src), .cfg_dst_i(cfg_dst), .cfg_word_i(cfg_word),
        .cfg_src_inc_i(src_inc), .cfg_dst_inc_i(dst_inc), .cfg_tend_en_i(tend_en),
        .en_set_i(en_set), .abort_i(abort), .hp_req_i(hp_req), .hp_grant_o(hp_grant),
        .bus_addr_o(bus_addr), .bus_rd_o(bus_rd), .bus_wr_o(bus_wr), .bus_word_o(bus_word),
        .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .tend_o(tend),
        .bus_rel_o(bus_rel), .done_o(done), .busy_o(busy), .chan_en_o(chan_en),
        .rem_count_o(rem_count), .cur_src_o(cur_src), .cur_dst_o(cur_dst)
    );

    int checks = 0;
    int errors = 0;
    int done_seen = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1-2 read, 3-4 write, 5 dead, 6 release
    int            m_ph;
    bit            m_en, m_word, m_si, m_di, m_te, m_fin, en_n;
    logic [CW-1:0] m_cnt;
    logic [AW-1:0] m_src, m_dst;
    logic [DW-1:0] m_data;
    int            step;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_en = 0; m_cnt = '0; m_src = '0; m_dst = '0; m_data = '0;
            m_word = 0; m_si = 0; m_di = 0; m_te = 0; m_fin = 0;
        end else begin
            en_n = m_en;
            if (abort) en_n = 0;
            else if (en_set || (start && m_ph == 0)) en_n = 1;
            step = m_word ? 2 : 1;
            case (m_ph)
                0: begin
                    if (start) begin
                        m_cnt = cfg_count; m_src = cfg_src; m_dst = cfg_dst;
                        m_word = cfg_word; m_si = src_inc; m_di = dst_inc; m_te = tend_en;
                    end else if (m_en && !abort && m_cnt != 0 && !hp_req) m_ph = 1;
                end
                1: m_ph = 2;
                2: begin m_data = mem_of(m_src); m_ph = 3; end
                3: m_ph = 4;
                4: begin
                    m_cnt = m_cnt - 1'b1;
                    if (m_si) m_src = m_src + AW'(step);
                    if (m_di) m_dst = m_dst + AW'(step);
                    if (m_cnt == 0) begin m_ph = 5; m_fin = 1; end
                    else if (!en_n) begin m_ph = 6; m_fin = 0; end
                    else m_ph = 1;
                end
                5: m_ph = 6;
                default: m_ph = 0;
            endcase
            m_en = en_n;
        end
        #2;
        if (rst_n) begin
            check(bus_rd == (m_ph == 1 || m_ph == 2), "R2", "bus_rd", bus_rd, (m_ph == 1 || m_ph == 2));
            check(bus_wr == (m_ph == 3 || m_ph == 4), "R2", "bus_wr", bus_wr, (m_ph == 3 || m_ph == 4));
            check(bus_addr == ((m_ph == 1 || m_ph == 2) ? m_src : (m_ph == 3 || m_ph == 4) ? m_dst : '0),
                  "R2", "bus_addr", bus_addr,
                  (m_ph == 1 || m_ph == 2) ? m_src : (m_ph == 3 || m_ph == 4) ? m_dst : '0);
            check(bus_wdata == ((m_ph == 3 || m_ph == 4) ? m_data : '0), "R2", "bus_wdata",
                  bus_wdata, (m_ph == 3 || m_ph == 4) ? m_data : '0);
            check(bus_word == m_word, "R2", "bus_word", bus_word, m_word);
            check(busy == (m_ph != 0), "R3", "busy", busy, (m_ph != 0));
            check(rem_count == m_cnt, "R3", "rem_count", rem_count, m_cnt);
            check(cur_src == m_src, "R3", "cur_src", cur_src, m_src);
            check(cur_dst == m_dst, "R3", "cur_dst", cur_dst, m_dst);
            check(bus_rel == (m_ph == 6), "R4", "bus_rel", bus_rel, (m_ph == 6));
            check(done == (m_ph == 6 && m_fin), "R4", "done", done, (m_ph == 6 && m_fin));
            check(tend == (m_ph >= 1 && m_ph <= 4 && m_cnt == 1 && m_te), "R5", "tend", tend,
                  (m_ph >= 1 && m_ph <= 4 && m_cnt == 1 && m_te));
            check(hp_grant == (hp_req && m_ph == 0), "R6", "hp_grant", hp_grant, (hp_req && m_ph == 0));
            check(chan_en == m_en, "R7", "chan_en", chan_en, m_en);
            if (done) done_seen++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start(input int cnt, input logic [AW-1:0] s, input logic [AW-1:0] d,
                            input bit w, input bit si, input bit di, input bit te);
        @(negedge clk);
        cfg_count = CW'(cnt); cfg_src = s; cfg_dst = d;
        cfg_word = w; src_inc = si; dst_inc = di; tend_en = te; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20 && !busy; i++) @(negedge clk);
        for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    endtask

    initial begin
        int d0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1: reset state
        check(!busy && !chan_en && rem_count == 0 && cur_src == 0, "R1", "reset state",
              {busy, chan_en}, 0);

        // Word burst, both pointers increment, transfer-end enabled
        d0 = done_seen;
        do_start(3, 24'h001000, 24'h002000, 1, 1, 1, 1);
        wait_idle();
        check(done_seen == d0 + 1, "R4", "done pulses word burst", done_seen - d0, 1);
        check(cur_src == 24'h001006, "R3", "word source step", cur_src, 24'h001006);

        // Byte burst, fixed destination, transfer-end disabled
        do_start(2, 24'h003001, 24'h004000, 0, 1, 0, 0);
        wait_idle();
        check(cur_src == 24'h003003 && cur_dst == 24'h004000, "R3", "byte step fixed dest",
              cur_dst, 24'h004000);

        // Zero count: nothing runs
        d0 = done_seen;
        do_start(0, 24'h005000, 24'h006000, 1, 1, 1, 1);
        cyc(10);
        check(!busy && done_seen == d0, "R1", "zero count stays idle", busy, 0);

        // Higher-priority request pending before start blocks it
        hp_req = 1'b1;
        do_start(2, 24'h007000, 24'h008000, 1, 1, 1, 1);
        cyc(8);
        check(!busy && hp_grant, "R6", "pending request holds channel", busy, 0);
        hp_req = 1'b0;
        cyc(3);
        hp_req = 1'b1;
        cyc(1);
        check(busy && !hp_grant, "R6", "no grant mid-burst", hp_grant, 0);
        wait_idle();
        cyc(1);
        check(hp_grant, "R6", "grant after burst", hp_grant, 1);
        hp_req = 1'b0;

        // Abort during a non-final unit: suspend, then resume
        d0 = done_seen;
        do_start(4, 24'h009000, 24'h00A000, 1, 1, 1, 1);
        for (int i = 0; i < 20 && !bus_wr; i++) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        wait_idle();
        check(rem_count == 3 && done_seen == d0, "R8", "suspended count", rem_count, 3);
        check(cur_src == 24'h009002, "R8", "suspended source kept", cur_src, 24'h009002);
        check(!chan_en, "R7", "abort cleared enable", chan_en, 0);
        @(negedge clk);
        en_set = 1'b1;
        @(negedge clk);
        en_set = 1'b0;
        wait_idle();
        check(rem_count == 0 && cur_src == 24'h009008 && done_seen == d0 + 1, "R10",
              "resume completes", cur_src, 24'h009008);

        // Abort during the final unit: burst completes
        d0 = done_seen;
        do_start(1, 24'h00B000, 24'h00C000, 1, 1, 1, 1);
        for (int i = 0; i < 20 && !bus_rd; i++) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check(tend, "R9", "tend kept after abort", tend, 1);
        wait_idle();
        check(done_seen == d0 + 1 && rem_count == 0, "R9", "final unit completes",
              done_seen - d0, 1);

        // Abort and start together: enable stays clear
        @(negedge clk);
        cfg_count = 2; cfg_src = 24'h00D000; cfg_dst = 24'h00E000; cfg_word = 0;
        src_inc = 1; dst_inc = 1; tend_en = 0; start = 1'b1; abort = 1'b1;
        @(negedge clk);
        start = 1'b0; abort = 1'b0;
        cyc(6);
        check(!chan_en && !busy && rem_count == 2, "R7", "abort beats start", chan_en, 0);
        en_set = 1'b1;
        @(negedge clk);
        en_set = 1'b0;
        wait_idle();
        check(rem_count == 0 && cur_dst == 24'h00E002, "R10", "resume after loaded abort",
              cur_dst, 24'h00E002);

        cyc(3);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule